// File: doc/BRIEF.md
# Read-cleared interrupt flag controller

This block keeps an interrupt flag byte and an interrupt mask byte for a device reached over a serial bus. It drives one active-low interrupt line. Event pulses set flag bits, and the line is pulled low while any flag bit is set together with its mask bit. A serial-bus slave, which sits outside this block, reads the flag byte and then the mask byte. It also writes the mask. The slave reports the bus activity to this block as single-cycle strobes: read begins, byte acknowledged, stop seen, write begins, and write byte with its data.

Reading the registers is what clears them. The amount cleared depends on how far the read got. A read that stops after the flag byte clears only the flags. A read that completes the mask byte clears both registers. While a read is in progress, new events are held in a pending register and do not touch the flags. Pending events are merged into the flags when the read window closes, after any clear, so no event is lost.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag, mask and pending bytes are zero, `irq_n_o` is high and `rd_data_o` reads 0x00.
- R2: An event pulse that arrives while no read window is open sets its flag bit on the next clock edge. If the mask bit is set, `irq_n_o` goes low on that same edge.
- R3: `irq_n_o` is low exactly when (flag AND mask) is non-zero. A flag bit whose mask bit is clear never pulls the line low.
- R4: `rd_data_o` returns the flag byte from the start of a read until the first acknowledge. After that it returns the mask byte, until the window closes.
- R5: A read window opens on the edge after `rd_start_i`. Events that arrive while it is open change neither the flags nor `irq_n_o`; they are held as pending.
- R6: A stop that comes after the flag byte was acknowledged, but before the mask byte was, clears all flags and leaves the mask unchanged. A stop in the same cycle as the flag-byte acknowledge does the same. Pending events then set their flags.
- R7: The acknowledge that ends the mask byte clears every flag and mask bit and closes the window, and `irq_n_o` returns high. Pending events are then ORed into the flags. Further acknowledges before the stop have no effect.
- R8: A stop before any byte acknowledge closes the window without clearing anything and merges the pending events.
- R9: After `wr_start_i`, only the first `wr_byte_i` loads `wr_data_i` into the mask. If a flag already matches the new mask, `irq_n_o` goes low on the same edge. Later bytes of the same write leave the mask unchanged.
- R10: An event pulse in the cycle a window closes is not lost. Its flag is set after that cycle's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event pulses, one per flag bit |
| rd_start_i | input | 1 | Read access begins |
| rd_ack_i | input | 1 | A read data byte was acknowledged |
| stop_i | input | 1 | Stop condition seen |
| wr_start_i | input | 1 | Write access begins |
| wr_byte_i | input | 1 | A write data byte is ready |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Byte the slave returns in the current read slot |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is an event that coincides with the cycle the window closes. In that cycle the clear, the pending merge and the new event all land on the same edge. The stimulus places an event pulse exactly on the mask-byte acknowledge, and another on a flag-only stop. It then writes a full mask, so that every surviving flag becomes visible on the interrupt line and in the read data. A long pseudo-random run then mixes events with reads that end at all three points, and with writes of several bytes. The behavioural model is compared with the design every cycle throughout that run.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_FLAG  = 2'd1,
    RD_MASK  = 2'd2,
    RD_DRAIN = 2'd3
  } rd_phase_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_rd_window.sv
module irq_rd_window
  import irq_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start_i,
  input  logic rd_ack_i,
  input  logic stop_i,
  output logic win_open_o,
  output logic win_close_o,
  output logic clr_flag_o,
  output logic clr_mask_o,
  output logic sel_mask_o
);
  rd_phase_e phase_q, phase_nxt;
  logic close_nxt, cf_nxt, cm_nxt;

  always_comb begin
    phase_nxt = phase_q;
    close_nxt = 1'b0;
    cf_nxt    = 1'b0;
    cm_nxt    = 1'b0;
    unique case (phase_q)
      RD_IDLE, RD_DRAIN: begin
        if (rd_start_i)  phase_nxt = RD_FLAG;
        else if (stop_i) phase_nxt = RD_IDLE;
      end
      RD_FLAG: begin
        if (stop_i) begin
          close_nxt = 1'b1;
          cf_nxt    = rd_ack_i;
          phase_nxt = RD_IDLE;
        end else if (rd_ack_i) begin
          phase_nxt = RD_MASK;
        end
      end
      RD_MASK: begin
        if (rd_ack_i) begin
          close_nxt = 1'b1;
          cf_nxt    = 1'b1;
          cm_nxt    = 1'b1;
          phase_nxt = stop_i ? RD_IDLE : RD_DRAIN;
        end else if (stop_i) begin
          close_nxt = 1'b1;
          cf_nxt    = 1'b1;
          phase_nxt = RD_IDLE;
        end
      end
      default: phase_nxt = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= RD_IDLE;
    else        phase_q <= phase_nxt;
  end

  assign win_open_o  = (phase_q == RD_FLAG) || (phase_q == RD_MASK);
  assign sel_mask_o  = (phase_q == RD_MASK);
  assign win_close_o = close_nxt;
  assign clr_flag_o  = cf_nxt;
  assign clr_mask_o  = cm_nxt;
endmodule

// File: rtl/irq_evt_hold.sv
module irq_evt_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         win_open_i,
  input  logic         win_close_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] evt_direct_o
);
  logic [W-1:0] pend_q, pend_nxt;
  logic         hold_en;

  assign hold_en = win_open_i && !win_close_i;

  always_comb begin
    pend_nxt = pend_q;
    if (win_close_i)  pend_nxt = '0;
    else if (hold_en) pend_nxt = pend_q | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign pend_o       = pend_q;
  assign evt_direct_o = hold_en ? '0 : evt_i;
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_direct_i,
  input  logic [W-1:0] pend_i,
  input  logic         win_close_i,
  input  logic         clr_flag_i,
  input  logic         clr_mask_i,
  input  logic         wr_start_i,
  input  logic         wr_byte_i,
  input  logic         stop_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] mask_o,
  output logic         irq_n_o
);
  logic [W-1:0] flag_q, flag_nxt, mask_q, mask_nxt;
  logic         armed_q, armed_nxt, irq_n_q, irq_n_nxt;
  logic         mask_load;

  assign mask_load = wr_byte_i && armed_q;

  always_comb begin
    flag_nxt = clr_flag_i ? '0 : flag_q;
    flag_nxt = flag_nxt | evt_direct_i;
    if (win_close_i) flag_nxt = flag_nxt | pend_i;

    mask_nxt = mask_q;
    if (clr_mask_i)     mask_nxt = '0;
    else if (mask_load) mask_nxt = wr_data_i;

    armed_nxt = armed_q;
    if (wr_start_i)               armed_nxt = 1'b1;
    else if (wr_byte_i || stop_i) armed_nxt = 1'b0;

    irq_n_nxt = ~|(flag_nxt & mask_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      mask_q  <= '0;
      armed_q <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      flag_q  <= flag_nxt;
      mask_q  <= mask_nxt;
      armed_q <= armed_nxt;
      irq_n_q <= irq_n_nxt;
    end
  end

  assign flag_o  = flag_q;
  assign mask_o  = mask_q;
  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         rd_start_i,
  input  logic         rd_ack_i,
  input  logic         stop_i,
  input  logic         wr_start_i,
  input  logic         wr_byte_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  output logic         irq_n_o
);
  logic         rst_n_sync;
  logic         win_open, win_close, clr_flag, clr_mask, sel_mask;
  logic [W-1:0] pend_q, evt_direct, flag_q, mask_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  irq_rd_window u_win (
    .clk(clk), .rst_n(rst_n_sync),
    .rd_start_i(rd_start_i), .rd_ack_i(rd_ack_i), .stop_i(stop_i),
    .win_open_o(win_open), .win_close_o(win_close),
    .clr_flag_o(clr_flag), .clr_mask_o(clr_mask), .sel_mask_o(sel_mask)
  );

  irq_evt_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n_sync), .evt_i(evt_i),
    .win_open_i(win_open), .win_close_i(win_close),
    .pend_o(pend_q), .evt_direct_o(evt_direct)
  );

  irq_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync),
    .evt_direct_i(evt_direct), .pend_i(pend_q), .win_close_i(win_close),
    .clr_flag_i(clr_flag), .clr_mask_i(clr_mask),
    .wr_start_i(wr_start_i), .wr_byte_i(wr_byte_i), .stop_i(stop_i),
    .wr_data_i(wr_data_i),
    .flag_o(flag_q), .mask_o(mask_q), .irq_n_o(irq_n_o)
  );

  assign rd_data_o = sel_mask ? mask_q : flag_q;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_i,
  input logic         irq_n_o,
  input logic         win_open,
  input logic         win_close,
  input logic         clr_mask,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] pend_q
);
  // R3
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o == ~|(flag_q & mask_q));

  // R5
  held_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && !win_close) |=> $stable(flag_q));

  // R5
  pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> (pend_q == '0));

  // R7
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mask |=> (mask_q == '0));

  // R10
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open || win_close) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R7
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> ((flag_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .irq_n_o(irq_n_o),
  .win_open(win_open), .win_close(win_close), .clr_mask(clr_mask),
  .flag_q(flag_q), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       rd_start_i = 1'b0, rd_ack_i = 1'b0, stop_i = 1'b0;
  logic       wr_start_i = 1'b0, wr_byte_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_n_o;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    live = 0;

  // reference state: phase 0 idle, 1 flag byte, 2 mask byte, 3 drain
  int       m_ph;
  bit [7:0] m_f, m_m, m_p;
  bit       m_arm, m_irqn;

  always #2.5 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_start_i(rd_start_i),
    .rd_ack_i(rd_ack_i), .stop_i(stop_i), .wr_start_i(wr_start_i),
    .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_f = 0; m_m = 0; m_p = 0; m_arm = 0; m_irqn = 1;
    end else begin
      bit close, cf, cm, open;
      int nph;
      close = 0; cf = 0; cm = 0; nph = m_ph;
      open = (m_ph == 1) || (m_ph == 2);
      if (m_ph == 0 || m_ph == 3) begin
        if (rd_start_i) nph = 1; else if (stop_i) nph = 0;
      end else if (m_ph == 1) begin
        if (stop_i) begin close = 1; cf = rd_ack_i; nph = 0; end
        else if (rd_ack_i) nph = 2;
      end else begin
        if (rd_ack_i) begin close = 1; cf = 1; cm = 1; nph = stop_i ? 0 : 3; end
        else if (stop_i) begin close = 1; cf = 1; nph = 0; end
      end
      if (cf) m_f = 0;
      if (close) begin m_f = m_f | m_p | evt_i; m_p = 0; end
      else if (open) m_p = m_p | evt_i;
      else m_f = m_f | evt_i;
      if (cm) m_m = 0;
      else if (wr_byte_i && m_arm) m_m = wr_data_i;
      if (wr_start_i) m_arm = 1;
      else if (wr_byte_i || stop_i) m_arm = 0;
      m_irqn = ((m_f & m_m) == 0);
      m_ph = nph;
    end
  end

  task automatic cmp8(string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    cmp8("irq_n_o", {7'b0, irq_n_o}, {7'b0, m_irqn});
    cmp8("rd_data_o", rd_data_o, (m_ph == 2) ? m_m : m_f);
  end

  task automatic tick(input logic [7:0] ev, input bit rs, input bit ak,
                      input bit sp, input bit ws, input bit wb, input logic [7:0] wd);
    @(negedge clk);
    #0.1;
    evt_i = ev; rd_start_i = rs; rd_ack_i = ak; stop_i = sp;
    wr_start_i = ws; wr_byte_i = wb; wr_data_i = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic write_mask(logic [7:0] a, logic [7:0] b);
    tick(0, 0, 0, 0, 1, 0, 0);
    tick(0, 0, 0, 0, 0, 1, a);
    tick(0, 0, 0, 0, 0, 1, b);
    tick(0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    tag = "R1";
    cmp8("reset irq_n_o", {7'b0, irq_n_o}, 8'h01);
    cmp8("reset rd_data_o", rd_data_o, 8'h00);
    live = 1;
    idle(2);
    // R3 unmasked flags stay silent
    tag = "R3";
    tick(8'h05, 0, 0, 0, 0, 0, 0);
    idle(2);
    // R9 first byte loads mask, second ignored
    tag = "R9";
    write_mask(8'h04, 8'hFF);
    idle(2);
    // R2 event outside window
    tag = "R2";
    tick(8'h10, 0, 0, 0, 0, 0, 0);
    idle(2);
    // R4 and R5: read with events held
    tag = "R5";
    tick(0, 1, 0, 0, 0, 0, 0);
    tick(8'h02, 0, 0, 0, 0, 0, 0);
    idle(1);
    tag = "R4";
    tick(0, 0, 1, 0, 0, 0, 0);
    tick(8'h40, 0, 0, 0, 0, 0, 0);
    idle(1);
    // R7 and R10 mask-byte ack with coincident event
    tag = "R10";
    tick(8'h80, 0, 1, 0, 0, 0, 0);
    tag = "R7";
    idle(1);
    tick(0, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0);
    idle(2);
    tag = "R9";
    write_mask(8'hFF, 8'h00);
    idle(2);
    // R6 flag-only read with event at the stop
    tag = "R6";
    tick(0, 1, 0, 0, 0, 0, 0);
    tick(8'h01, 0, 1, 0, 0, 0, 0);
    tick(8'h20, 0, 0, 1, 0, 0, 0);
    idle(2);
    tick(0, 1, 0, 0, 0, 0, 0);
    tick(8'h08, 0, 1, 1, 0, 0, 0);
    idle(2);
    // R8 stop before any ack
    tag = "R8";
    tick(8'h03, 0, 0, 0, 0, 0, 0);
    tick(0, 1, 0, 0, 0, 0, 0);
    tick(8'h04, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0);
    idle(2);
    // R3 mixed pseudo-random traffic
    tag = "R3";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick((lfsr[3:0] == 0) ? (8'h01 << lfsr[6:4]) : 8'h00,
           lfsr[9:7] == 0, lfsr[11:10] == 0, lfsr[14:12] == 0,
           lfsr[15:13] == 3'd5, lfsr[2:0] == 3'd6, lfsr[15:8]);
    end
    idle(4);
    live = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule